// File: doc/BRIEF.md
# Extended-to-Narrow Floating-Point Rounder

This block converts an 80-bit extended-precision operand (sign, 15-bit biased exponent, 64-bit mantissa with an explicit integer bit) into a packed single-precision or double-precision value. A format select picks the target for each sample. A 2-bit rounding-mode input controls the narrowing. The unit returns the packed result together with the status bits C1 (the magnitude was rounded up), PE (the result is inexact), UE (the result is tiny and inexact), OE (the exponent overflowed) and IE (the operand is invalid). It also returns a precision indication gated by a mask input.

Each sample is classified first. Finite operands whose target exponent falls at or below zero are shifted into the subnormal position, and every bit lost in that shift is folded into a sticky bit. The mantissa is then rounded at the target precision. A round-to-nearest tie on an even kept bit is detected before any addition is made. A carry out of the kept field renormalises the value and raises the exponent by one. Zeros, infinities and quiet NaNs pass through in canonical form. Malformed operands produce a default NaN.

The unit is a single registered stage. It accepts one sample per clock, and results appear one cycle after the sample is accepted.

Top module: `xfp_narrow_round`

## Requirements
- R1: A sample presented with `in_valid` high produces `out_valid` high, together with its result and flags, after the next rising clock edge. After reset, `out_valid` and all outputs are 0.
- R2: With `fmt_dbl`=0 the single-precision result occupies `out_result[31:0]` (sign bit 31, exponent bits 30:23, fraction bits 22:0) and `out_result[63:32]` is 0. With `fmt_dbl`=1 the double-precision result uses sign bit 63, exponent bits 62:52 and fraction bits 51:0.
- R3: `rnd_mode` encodes 00 round to nearest even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. A directed mode increments the magnitude only when the discarded bits are nonzero and the direction points away from zero for the operand's sign. Mode 11 never increments.
- R4: In mode 00, discarded bits exactly equal to one half unit with a kept LSB of 0 cause no increment. The same tie with a kept LSB of 1 causes an increment.
- R5: An increment that carries out of the kept mantissa produces a zero fraction and raises the exponent by one.
- R6: A finite operand whose biased target exponent is 0 or less is shifted right by (1 − exponent), with the lost bits kept as a sticky bit. Its exponent field is 0, or 1 if rounding carries the value into the smallest normal number.
- R7: PE is set when any discarded bit is nonzero, and C1 is set when rounding increased the magnitude. `pe_unmasked` equals PE AND NOT `pe_mask`.
- R8: UE is set when the target exponent before rounding is 0 or less and the result is inexact.
- R9: A rounded exponent that reaches the all-ones field sets OE and PE. The result is infinity with C1=1 in mode 00 or in a mode directed away from zero for the sign. Otherwise the result is the largest finite value of that sign with C1=0.
- R10: Signed zero and infinity (exponent 7FFF, mantissa 8000_0000_0000_0000) map to the target's signed zero and infinity. A quiet NaN (exponent 7FFF, mantissa bits 63:62 = 11) maps to the canonical quiet NaN with its sign kept. None of these raises a flag.
- R11: An invalid operand sets IE and produces the default NaN (sign 1, all-ones exponent, only the top fraction bit set). Invalid operands are: a signaling NaN, exponent 7FFF with integer bit 0, or a nonzero exponent with integer bit 0. All other flags stay 0 for such an operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present on the inputs |
| in_value | input | 80 | Extended operand: sign bit 79, exponent 78:64, mantissa 63:0 |
| fmt_dbl | input | 1 | 0 selects single precision, 1 selects double precision |
| rnd_mode | input | 2 | Rounding mode, encoded as given in R3 |
| pe_mask | input | 1 | Suppresses `pe_unmasked` |
| out_valid | output | 1 | Result registered for the previous sample |
| out_result | output | 64 | Packed narrowed value |
| flag_c1 | output | 1 | Magnitude was rounded up |
| flag_pe | output | 1 | Inexact result |
| flag_ue | output | 1 | Tiny and inexact result |
| flag_oe | output | 1 | Exponent overflow |
| flag_ie | output | 1 | Invalid operand |
| pe_unmasked | output | 1 | PE not suppressed by the mask |

## Verification
The clocked properties assume that every input is at a known value in any cycle where `in_valid` is high. The flag properties rely only on relations between registered outputs, such as an invalid operand never being reported as inexact. The stimulus keeps `in_valid` low except in one cycle per sample, and it drives every input in that cycle. The random operands take their target exponents from a window that covers deep underflow, subnormal, normal and overflow territory. The random generator forces exact ties and all-ones kept mantissas in fixed fractions of the draws, so that the tie-to-even and carry paths occur often.

// File: rtl/xnr_pkg.sv
package xnr_pkg;

    localparam int EXT_EXP_W = 15;
    localparam int EXT_MAN_W = 64;
    localparam int EXT_BIAS  = 16383;

    localparam int SGL_EXP_W = 8;
    localparam int SGL_FRAC  = 23;
    localparam int SGL_BIAS  = 127;
    localparam int DBL_EXP_W = 11;
    localparam int DBL_FRAC  = 52;
    localparam int DBL_BIAS  = 1023;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_mode_e;

    typedef enum logic [2:0] {
        CLS_FIN,
        CLS_ZERO,
        CLS_INF,
        CLS_QNAN,
        CLS_BAD
    } opnd_cls_e;

    typedef struct packed {
        logic        valid;
        logic [63:0] result;
        logic        c1;
        logic        pe;
        logic        ue;
        logic        oe;
        logic        ie;
        logic        pe_trap;
    } out_reg_t;

endpackage

// File: rtl/xnr_classify.sv
module xnr_classify
    import xnr_pkg::*;
#(
    parameter int EW = 18
) (
    input  logic [79:0]          ext_val,
    input  logic                 fmt_dbl,
    output opnd_cls_e            cls_o,
    output logic                 sign_o,
    output logic signed [EW-1:0] exp_o,
    output logic [EXT_MAN_W-1:0] man_o
);

    localparam logic [EXT_EXP_W-1:0] EXP_ALL1 = '1;
    localparam logic [EXT_MAN_W-1:0] INF_MAN  = {1'b1, {(EXT_MAN_W-1){1'b0}}};

    logic [EXT_EXP_W-1:0] ex_raw;
    logic [EXT_EXP_W-1:0] ex_eff;
    logic [EW-1:0]        tgt_bias;

    always_comb begin
        sign_o  = ext_val[79];
        ex_raw  = ext_val[78:64];
        man_o   = ext_val[63:0];
        ex_eff  = (ex_raw == '0) ? EXT_EXP_W'(1) : ex_raw;
        tgt_bias = fmt_dbl ? EW'(DBL_BIAS) : EW'(SGL_BIAS);
        exp_o   = EW'({{(EW-EXT_EXP_W){1'b0}}, ex_eff}) - EW'(EXT_BIAS) + tgt_bias;

        if (ex_raw == EXP_ALL1) begin
            if (man_o == INF_MAN)
                cls_o = CLS_INF;
            else if (man_o[63:62] == 2'b11)
                cls_o = CLS_QNAN;
            else
                cls_o = CLS_BAD;
        end else if (ex_raw != '0 && !man_o[63]) begin
            cls_o = CLS_BAD;
        end else if (ex_raw == '0 && man_o == '0) begin
            cls_o = CLS_ZERO;
        end else begin
            cls_o = CLS_FIN;
        end
    end

endmodule

// File: rtl/xnr_denorm.sv
module xnr_denorm #(
    parameter int MAN_W = 64,
    parameter int EW    = 18
) (
    input  logic signed [EW-1:0] exp_i,
    input  logic [MAN_W-1:0]     man_i,
    output logic signed [EW-1:0] exp_o,
    output logic [MAN_W-1:0]     man_o,
    output logic                 tiny_o
);

    localparam int SH_W = $clog2(MAN_W);

    logic [EW-1:0]    shift;
    logic [SH_W-1:0]  sh_lo;
    logic [MAN_W-1:0] lost_mask;
    logic             sticky;

    always_comb begin
        shift     = EW'(1) - exp_i;
        sh_lo     = shift[SH_W-1:0];
        lost_mask = (MAN_W'(1) << sh_lo) - MAN_W'(1);
        sticky    = |(man_i & lost_mask);
        tiny_o    = (exp_i <= 0);

        if (!tiny_o) begin
            exp_o = exp_i;
            man_o = man_i;
        end else if (shift >= EW'(MAN_W)) begin
            exp_o = '0;
            man_o = {{(MAN_W-1){1'b0}}, |man_i};
        end else begin
            exp_o = '0;
            man_o = (man_i >> sh_lo) | {{(MAN_W-1){1'b0}}, sticky};
        end
    end

endmodule

// File: rtl/xnr_round_lane.sv
module xnr_round_lane
    import xnr_pkg::*;
#(
    parameter int MAN_W  = 64,
    parameter int EW     = 18,
    parameter int FRAC_W = 23,
    parameter int EXP_W  = 8
) (
    input  logic [MAN_W-1:0]     man_i,
    input  logic signed [EW-1:0] exp_i,
    input  logic                 sign_i,
    input  rnd_mode_e            rc_i,
    output logic [FRAC_W-1:0]    frac_o,
    output logic [EXP_W-1:0]     exp_o,
    output logic                 inc_o,
    output logic                 inexact_o,
    output logic                 ovf_o,
    output logic                 to_inf_o
);

    localparam int DROP = MAN_W - 1 - FRAC_W;
    localparam int KW   = FRAC_W + 1;
    localparam logic [DROP-1:0]     HALF = {1'b1, {(DROP-1){1'b0}}};
    localparam logic signed [EW-1:0] EMAX = EW'((1 << EXP_W) - 1);

    logic [DROP-1:0]     roff;
    logic [KW-1:0]       kept;
    logic [KW:0]         kept_r;
    logic                near, away, tie_even, carry;
    logic signed [EW-1:0] exp_full;

    always_comb begin
        roff      = man_i[DROP-1:0];
        kept      = man_i[MAN_W-1:DROP];
        near      = (rc_i == RND_NEAR);
        away      = (rc_i == RND_UP && !sign_i) || (rc_i == RND_DOWN && sign_i);
        tie_even  = near && !kept[0] && (roff == HALF);
        inexact_o = |roff;

        if (near)
            inc_o = (roff >= HALF) && !tie_even;
        else
            inc_o = away && inexact_o;

        kept_r = {1'b0, kept} + (KW+1)'(inc_o);
        carry  = kept_r[KW];

        if (carry)
            exp_full = exp_i + EW'(1);
        else if (exp_i == 0 && kept_r[KW-1])
            exp_full = EW'(1);
        else
            exp_full = exp_i;

        frac_o   = carry ? '0 : kept_r[FRAC_W-1:0];
        exp_o    = exp_full[EXP_W-1:0];
        ovf_o    = (exp_full >= EMAX);
        to_inf_o = near || away;
    end

endmodule

// File: rtl/xfp_narrow_round.sv
module xfp_narrow_round
    import xnr_pkg::*;
#(
    parameter int WORK_EXP_W = 18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [79:0] in_value,
    input  logic        fmt_dbl,
    input  logic [1:0]  rnd_mode,
    input  logic        pe_mask,
    output logic        out_valid,
    output logic [63:0] out_result,
    output logic        flag_c1,
    output logic        flag_pe,
    output logic        flag_ue,
    output logic        flag_oe,
    output logic        flag_ie,
    output logic        pe_unmasked
);

    localparam int EW = WORK_EXP_W;

    opnd_cls_e            cls;
    logic                 sgn;
    logic signed [EW-1:0] exp_cl, exp_dn;
    logic [EXT_MAN_W-1:0] man_cl, man_dn;
    logic                 tiny;
    rnd_mode_e            rc;

    logic [SGL_FRAC-1:0]  s_frac;
    logic [SGL_EXP_W-1:0] s_exp;
    logic                 s_inc, s_inx, s_ovf, s_inf;
    logic [DBL_FRAC-1:0]  d_frac;
    logic [DBL_EXP_W-1:0] d_exp;
    logic                 d_inc, d_inx, d_ovf, d_inf;

    logic [63:0] res_c;
    logic        c1_c, pe_c, ue_c, oe_c, ie_c;
    logic        l_inc, l_inx, l_ovf, l_inf;
    logic [63:0] fin_pat, inf_pat, max_pat, zero_pat, qnan_pat, dnan_pat;

    out_reg_t out_d, out_q;

    assign rc = rnd_mode_e'(rnd_mode);

    xnr_classify #(.EW(EW)) u_cls (
        .ext_val (in_value),
        .fmt_dbl (fmt_dbl),
        .cls_o   (cls),
        .sign_o  (sgn),
        .exp_o   (exp_cl),
        .man_o   (man_cl)
    );

    xnr_denorm #(.MAN_W(EXT_MAN_W), .EW(EW)) u_den (
        .exp_i  (exp_cl),
        .man_i  (man_cl),
        .exp_o  (exp_dn),
        .man_o  (man_dn),
        .tiny_o (tiny)
    );

    xnr_round_lane #(.MAN_W(EXT_MAN_W), .EW(EW), .FRAC_W(SGL_FRAC), .EXP_W(SGL_EXP_W)) u_sgl (
        .man_i     (man_dn),
        .exp_i     (exp_dn),
        .sign_i    (sgn),
        .rc_i      (rc),
        .frac_o    (s_frac),
        .exp_o     (s_exp),
        .inc_o     (s_inc),
        .inexact_o (s_inx),
        .ovf_o     (s_ovf),
        .to_inf_o  (s_inf)
    );

    xnr_round_lane #(.MAN_W(EXT_MAN_W), .EW(EW), .FRAC_W(DBL_FRAC), .EXP_W(DBL_EXP_W)) u_dbl (
        .man_i     (man_dn),
        .exp_i     (exp_dn),
        .sign_i    (sgn),
        .rc_i      (rc),
        .frac_o    (d_frac),
        .exp_o     (d_exp),
        .inc_o     (d_inc),
        .inexact_o (d_inx),
        .ovf_o     (d_ovf),
        .to_inf_o  (d_inf)
    );

    // Encoding patterns for the selected target format
    always_comb begin
        if (fmt_dbl) begin
            fin_pat  = {sgn, d_exp, d_frac};
            inf_pat  = {sgn, {DBL_EXP_W{1'b1}}, {DBL_FRAC{1'b0}}};
            max_pat  = {sgn, {(DBL_EXP_W-1){1'b1}}, 1'b0, {DBL_FRAC{1'b1}}};
            zero_pat = {sgn, 63'h0};
            qnan_pat = {sgn, {DBL_EXP_W{1'b1}}, 1'b1, {(DBL_FRAC-1){1'b0}}};
            dnan_pat = {1'b1, {DBL_EXP_W{1'b1}}, 1'b1, {(DBL_FRAC-1){1'b0}}};
        end else begin
            fin_pat  = {32'h0, sgn, s_exp, s_frac};
            inf_pat  = {32'h0, sgn, {SGL_EXP_W{1'b1}}, {SGL_FRAC{1'b0}}};
            max_pat  = {32'h0, sgn, {(SGL_EXP_W-1){1'b1}}, 1'b0, {SGL_FRAC{1'b1}}};
            zero_pat = {32'h0, sgn, 31'h0};
            qnan_pat = {32'h0, sgn, {SGL_EXP_W{1'b1}}, 1'b1, {(SGL_FRAC-1){1'b0}}};
            dnan_pat = {32'h0, 1'b1, {SGL_EXP_W{1'b1}}, 1'b1, {(SGL_FRAC-1){1'b0}}};
        end
        l_inc = fmt_dbl ? d_inc : s_inc;
        l_inx = fmt_dbl ? d_inx : s_inx;
        l_ovf = fmt_dbl ? d_ovf : s_ovf;
        l_inf = fmt_dbl ? d_inf : s_inf;
    end

    // Result and flag selection, next-state computation
    always_comb begin
        res_c = '0;
        c1_c  = 1'b0;
        pe_c  = 1'b0;
        ue_c  = 1'b0;
        oe_c  = 1'b0;
        ie_c  = 1'b0;
        unique case (cls)
            CLS_ZERO: res_c = zero_pat;
            CLS_INF:  res_c = inf_pat;
            CLS_QNAN: res_c = qnan_pat;
            CLS_BAD: begin
                res_c = dnan_pat;
                ie_c  = 1'b1;
            end
            default: begin
                if (l_ovf) begin
                    res_c = l_inf ? inf_pat : max_pat;
                    c1_c  = l_inf;
                    pe_c  = 1'b1;
                    oe_c  = 1'b1;
                end else begin
                    res_c = fin_pat;
                    c1_c  = l_inc;
                    pe_c  = l_inx;
                    ue_c  = tiny && l_inx;
                end
            end
        endcase

        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.result  = res_c;
            out_d.c1      = c1_c;
            out_d.pe      = pe_c;
            out_d.ue      = ue_c;
            out_d.oe      = oe_c;
            out_d.ie      = ie_c;
            out_d.pe_trap = pe_c && !pe_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign out_valid   = out_q.valid;
    assign out_result  = out_q.result;
    assign flag_c1     = out_q.c1;
    assign flag_pe     = out_q.pe;
    assign flag_ue     = out_q.ue;
    assign flag_oe     = out_q.oe;
    assign flag_ie     = out_q.ie;
    assign pe_unmasked = out_q.pe_trap;

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
    AST_SGL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !fmt_dbl) |=> (out_result[63:32] == 32'h0)); // R2
    AST_TRUNC_NO_C1: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && rnd_mode == 2'b11) |=> !flag_c1); // R3
    AST_C1_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && flag_c1) |-> flag_pe); // R7
    AST_TRAP_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && pe_unmasked) |-> flag_pe); // R7
    AST_UE_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && flag_ue) |-> flag_pe); // R8
    AST_OE_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && flag_oe) |-> (flag_pe && !flag_ue)); // R9
    AST_IE_ALONE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && flag_ie) |-> !(flag_pe || flag_ue || flag_oe || flag_c1)); // R11

endmodule

// File: tb/xfp_narrow_round_bench.sv
module xfp_narrow_round_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [79:0] in_value = '0;
    logic        fmt_dbl = 1'b0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        pe_mask = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        flag_c1, flag_pe, flag_ue, flag_oe, flag_ie, pe_unmasked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    xfp_narrow_round u_xfp_narrow_round (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .fmt_dbl(fmt_dbl), .rnd_mode(rnd_mode), .pe_mask(pe_mask),
        .out_valid(out_valid), .out_result(out_result), .flag_c1(flag_c1),
        .flag_pe(flag_pe), .flag_ue(flag_ue), .flag_oe(flag_oe),
        .flag_ie(flag_ie), .pe_unmasked(pe_unmasked)
    );

    // Reference: guard/sticky formulation; flags packed as {c1,pe,ue,oe,ie}
    function automatic void ref_model(input logic [79:0] x, input logic [1:0] rc,
                                      input logic dbl, output logic [63:0] r,
                                      output logic [4:0] fl);
        logic        sg = x[79];
        logic [14:0] ex = x[78:64];
        logic [63:0] mn = x[63:0];
        int F    = dbl ? 52 : 23;
        int EMAX = dbl ? 2047 : 255;
        int BIAS = dbl ? 1023 : 127;
        int eo, e2, s;
        logic [63:0] q, q2;
        logic g, st, inc, away;
        r = '0; fl = '0;
        if ((ex == 15'h7FFF && mn != 64'h8000_0000_0000_0000 && mn[63:62] != 2'b11) ||
            (ex != 0 && ex != 15'h7FFF && !mn[63])) begin
            r  = dbl ? 64'hFFF8_0000_0000_0000 : 64'h0000_0000_FFC0_0000;
            fl = 5'b00001;
        end else if (ex == 15'h7FFF && mn[63:62] == 2'b11) begin
            r = dbl ? {sg, 11'h7FF, 1'b1, 51'h0} : {32'h0, sg, 8'hFF, 1'b1, 22'h0};
        end else if (ex == 15'h7FFF) begin
            r = dbl ? {sg, 11'h7FF, 52'h0} : {32'h0, sg, 8'hFF, 23'h0};
        end else if (ex == 0 && mn == 0) begin
            r = dbl ? {sg, 63'h0} : {32'h0, sg, 31'h0};
        end else begin
            eo = ((ex == 0) ? 1 : int'(ex)) - 16383 + BIAS;
            s  = 63 - F + ((eo < 1) ? (1 - eo) : 0);
            q  = (s >= 64) ? 64'h0 : (mn >> s);
            g  = (s >= 1 && s <= 64) ? mn[s-1] : 1'b0;
            if (s <= 1)       st = 1'b0;
            else if (s > 64)  st = |mn;
            else              st = |(mn & ((64'd1 << (s - 1)) - 64'd1));
            away = (rc == 2'b10 && !sg) || (rc == 2'b01 && sg);
            if (rc == 2'b00) inc = g && (st || q[0]);
            else             inc = away && (g || st);
            q2 = q + {63'h0, inc};
            if (eo >= 1) begin
                e2 = eo;
                if (q2[F+1]) begin q2 = q2 >> 1; e2 = eo + 1; end
            end else begin
                e2 = q2[F] ? 1 : 0;
            end
            if (e2 >= EMAX) begin
                if (rc == 2'b00 || away) begin
                    r = dbl ? {sg, 11'h7FF, 52'h0} : {32'h0, sg, 8'hFF, 23'h0};
                    fl = 5'b11010;
                end else begin
                    r = dbl ? {sg, 11'h7FE, {52{1'b1}}} : {32'h0, sg, 8'hFE, {23{1'b1}}};
                    fl = 5'b01010;
                end
            end else begin
                r  = dbl ? {sg, e2[10:0], q2[51:0]} : {32'h0, sg, e2[7:0], q2[22:0]};
                fl = {inc, g || st, (eo < 1) && (g || st), 1'b0, 1'b0};
            end
        end
    endfunction

    task automatic apply(input logic [79:0] x, input logic [1:0] rc,
                         input logic dbl, input logic msk);
        @(negedge clk);
        in_value = x; rnd_mode = rc; fmt_dbl = dbl; pe_mask = msk; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic compare(input string tag, input logic [63:0] er,
                           input logic [4:0] ef, input logic ep);
        logic [4:0] gf = {flag_c1, flag_pe, flag_ue, flag_oe, flag_ie};
        checks++;
        if (out_valid !== 1'b1 || out_result !== er || gf !== ef || pe_unmasked !== ep) begin
            fails++;
            $display("FAIL %s: valid %b result %h flags %b trap %b, expected valid 1 result %h flags %b trap %b",
                     tag, out_valid, out_result, gf, pe_unmasked, er, ef, ep);
        end
    endtask

    task automatic run_ref(input string tag, input logic [79:0] x, input logic [1:0] rc,
                           input logic dbl, input logic msk);
        logic [63:0] er;
        logic [4:0]  ef;
        ref_model(x, rc, dbl, er, ef);
        apply(x, rc, dbl, msk);
        compare(tag, er, ef, ef[3] && !msk);
    endtask

    task automatic run_fix(input string tag, input logic [79:0] x, input logic [1:0] rc,
                           input logic dbl, input logic msk, input logic [63:0] er,
                           input logic [4:0] ef);
        apply(x, rc, dbl, msk);
        compare(tag, er, ef, ef[3] && !msk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [79:0] x;
        logic [63:0] m;
        int eo, bias, emax, d, kind;
        logic dbl;
        void'($urandom(32'h5EED_0412));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_result !== 64'h0 || flag_pe !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: valid %b result %h, expected 0 0", out_valid, out_result);
        end

        // R2 format placement
        run_fix("R2 one single", {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000}, 2'b00, 1'b0, 1'b0, 64'h3F80_0000, 5'b00000);
        run_fix("R2 one double", {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000}, 2'b00, 1'b1, 1'b0, 64'h3FF0_0000_0000_0000, 5'b00000);
        // R1 valid drops after an idle cycle
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle: valid %b, expected 0", out_valid);
        end
        // R4 ties
        run_fix("R4 tie even", {1'b0, 15'h3FFF, 64'h8000_0080_0000_0000}, 2'b00, 1'b0, 1'b0, 64'h3F80_0000, 5'b01000);
        run_fix("R4 tie odd",  {1'b0, 15'h3FFF, 64'h8000_0180_0000_0000}, 2'b00, 1'b0, 1'b0, 64'h3F80_0002, 5'b11000);
        // R5 carry out
        run_fix("R5 carry", {1'b0, 15'h3FFF, 64'hFFFF_FF80_0000_0000}, 2'b00, 1'b0, 1'b0, 64'h4000_0000, 5'b11000);
        // R3 directed modes
        run_fix("R3 up pos",   {1'b0, 15'h3FFF, 64'h8000_0000_0000_0001}, 2'b10, 1'b0, 1'b0, 64'h3F80_0001, 5'b11000);
        run_fix("R3 down pos", {1'b0, 15'h3FFF, 64'h8000_0000_0000_0001}, 2'b01, 1'b0, 1'b0, 64'h3F80_0000, 5'b01000);
        run_fix("R3 down neg", {1'b1, 15'h3FFF, 64'h8000_0000_0000_0001}, 2'b01, 1'b0, 1'b0, 64'hBF80_0001, 5'b11000);
        run_fix("R3 zero neg", {1'b1, 15'h3FFF, 64'hFFFF_FFFF_FFFF_FFFF}, 2'b11, 1'b0, 1'b0, 64'hBFFF_FFFF, 5'b01000);
        // R6 subnormals
        run_fix("R6 exact sub", {1'b0, 15'h3F80, 64'h8000_0000_0000_0000}, 2'b00, 1'b0, 1'b0, 64'h0040_0000, 5'b00000);
        run_fix("R6 to min normal", {1'b0, 15'h3F80, 64'hFFFF_FFFF_FFFF_FFFF}, 2'b00, 1'b0, 1'b0, 64'h0080_0000, 5'b11100);
        // R8 deep underflow
        run_fix("R8 tiny near", {1'b0, 15'h3F62, 64'h8000_0000_0000_0000}, 2'b00, 1'b0, 1'b0, 64'h0000_0000, 5'b01100);
        run_fix("R8 tiny up",   {1'b0, 15'h3F62, 64'h8000_0000_0000_0000}, 2'b10, 1'b0, 1'b0, 64'h0000_0001, 5'b11100);
        run_fix("R8 ext denormal", {1'b1, 15'h0000, 64'h0000_0000_0000_0001}, 2'b01, 1'b1, 1'b0, 64'h8000_0000_0000_0001, 5'b11100);
        // R9 overflow
        run_fix("R9 ovf near", {1'b0, 15'h407F, 64'h8000_0000_0000_0000}, 2'b00, 1'b0, 1'b0, 64'h7F80_0000, 5'b11010);
        run_fix("R9 ovf zero", {1'b0, 15'h407F, 64'h8000_0000_0000_0000}, 2'b11, 1'b0, 1'b0, 64'h7F7F_FFFF, 5'b01010);
        run_fix("R9 ovf neg up", {1'b1, 15'h407F, 64'h8000_0000_0000_0000}, 2'b10, 1'b0, 1'b0, 64'hFF7F_FFFF, 5'b01010);
        run_fix("R9 ovf by round", {1'b0, 15'h407E, 64'hFFFF_FFFF_FFFF_FFFF}, 2'b00, 1'b0, 1'b0, 64'h7F80_0000, 5'b11010);
        // R10 pass-through values
        run_fix("R10 neg zero", {1'b1, 15'h0000, 64'h0}, 2'b00, 1'b0, 1'b0, 64'h8000_0000, 5'b00000);
        run_fix("R10 inf", {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000}, 2'b00, 1'b1, 1'b0, 64'h7FF0_0000_0000_0000, 5'b00000);
        run_fix("R10 qnan", {1'b0, 15'h7FFF, 64'hC000_0000_0000_1234}, 2'b01, 1'b0, 1'b0, 64'h7FC0_0000, 5'b00000);
        // R11 invalid operands
        run_fix("R11 snan", {1'b0, 15'h7FFF, 64'h8000_0000_0000_0001}, 2'b00, 1'b1, 1'b0, 64'hFFF8_0000_0000_0000, 5'b00001);
        run_fix("R11 unnormal", {1'b0, 15'h3FFF, 64'h4000_0000_0000_0000}, 2'b00, 1'b0, 1'b0, 64'hFFC0_0000, 5'b00001);
        // R7 precision mask
        run_fix("R7 masked", {1'b0, 15'h3FFF, 64'h8000_0000_0000_0001}, 2'b11, 1'b0, 1'b1, 64'h3F80_0000, 5'b01000);
        run_fix("R7 unmasked", {1'b0, 15'h3FFF, 64'h8000_0000_0000_0001}, 2'b11, 1'b1, 1'b0, 64'h3FF0_0000_0000_0000, 5'b01000);

        // Constrained random against the reference (R3 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < 4000; i++) begin
            dbl  = 1'($urandom % 2);
            bias = dbl ? 1023 : 127;
            emax = dbl ? 2047 : 255;
            d    = dbl ? 11 : 40;
            kind = int'($urandom % 10);
            m    = {1'b1, 31'($urandom), $urandom};
            if (kind == 0) begin
                x = {$urandom, $urandom, 16'($urandom)};
            end else begin
                if (kind < 4) eo = int'($urandom % 80) - 70;
                else          eo = int'($urandom % 32'(emax + 75)) - 70;
                if (kind < 3 || kind == 6)
                    m = (m & ~((64'd1 << d) - 64'd1)) | (64'd1 << (d - 1));
                if (kind == 7)
                    m = m | ~((64'd1 << d) - 64'd1);
                x = {1'($urandom % 2), 15'(eo + 16383 - bias), m};
            end
            run_ref("R3 random vs model", x, 2'($urandom % 4), dbl, 1'($urandom % 2));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule